// File: doc/BRIEF.md
# Interlocked Endpoint Receive FIFO

This block sits between a USB packet engine and the CPU or DMA side of one OUT endpoint. The packet engine hands it the bytes of a packet one at a time. The block stores them and presents them as 16-bit little-endian words through a read port. A data-available request stays high for as long as at least one complete word can be read. At the end of the packet it pulses a receive-done interrupt, stores the packet's byte count together with an error flag, and locks. While locked it refuses all further packet traffic and signals NAK back to the engine.

Software reads the byte-count register to learn the packet length and whether the packet was bad. Reading that register also releases the lock, so the next packet can be accepted. Words still held in the store may be read before or after the release. A packet with an odd number of bytes is padded to a whole word with a zero byte. A flush command empties the store and returns the block to its open state at any time.

Top module: `ep_rx_fifo`

## Requirements
- R1: `rd_data_o` shows the oldest unread byte pair as {later byte, earlier byte}. `word_req_o` is high whenever at least one complete word is stored. A read strobe while `word_req_o` is high removes exactly that word by the next cycle.
- R2: An end-of-packet strobe accepted in the open state drives `done_irq_o` high for exactly the following cycle.
- R3: From the cycle after end of packet, `cnt_o[14:0]` holds the number of bytes accepted in that packet. `cnt_o[15]` holds `rx_err_i` as sampled at end of packet, ORed with any overflow.
- R4: From end of packet until release, `rx_nak_o` is high. Bytes and end-of-packet strobes arriving in that time are not stored, do not change `cnt_o` and raise no interrupt.
- R5: A strobe on `cnt_rd_i` while locked releases the lock: in the next cycle `rx_nak_o` is low and `cnt_o` is zero.
- R6: A packet with an odd byte count has its last word presented with the upper byte zero.
- R7: A zero-length packet pulses `done_irq_o` and locks the block, but never raises `word_req_o`. A count read is still needed to release it.
- R8: A byte that arrives while the store holds DEPTH bytes is dropped, is not counted, and sets `cnt_o[15]`.
- R9: A pulse on `flush_i` leaves, in the next cycle, `word_req_o` low, `rx_nak_o` low and `cnt_o` zero.
- R10: In the open state, `cnt_o` shows the running count with the overflow flag on top. A count read there changes nothing. A read strobe while `word_req_o` is low changes nothing.
- R11: After reset, `rx_nak_o`, `word_req_o` and `done_irq_o` are low and `cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Packet engine presents a byte |
| rx_byte_i | input | 8 | Received byte |
| rx_eop_i | input | 1 | End-of-packet strobe (no byte in the same cycle) |
| rx_err_i | input | 1 | Packet error status, sampled with rx_eop_i |
| rx_nak_o | output | 1 | Block is locked and refuses packet data |
| rd_word_i | input | 1 | Read strobe of the word data register |
| rd_data_o | output | 16 | Oldest stored word, zero when none |
| word_req_o | output | 1 | A complete word is available |
| done_irq_o | output | 1 | One-cycle receive-done interrupt |
| cnt_rd_i | input | 1 | Read strobe of the byte-count register |
| cnt_o | output | 16 | {error flag, byte count} |
| flush_i | input | 1 | Command write that flushes the FIFO |

## Verification
A corrupt read or write pointer shows up on the first word read after it occurs, as a wrong or misaligned byte pair on `rd_data_o`. An occupancy error shows as `word_req_o` staying high past the last stored word, or dropping early. A lock state that fails to set or clear shows within one cycle on `rx_nak_o` and `cnt_o`. It also shows as bytes from a refused packet reappearing in the word stream. Skipped or extra pad bytes misalign every later word, so the bench reads back packets of random length and parity, one after another, against a byte-queue model.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned LEN_W = REG_W - 1;

  typedef enum logic [1:0] {
    ST_OPEN   = 2'd0,
    ST_PAD    = 2'd1,
    ST_LOCKED = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rx_byte_store.sv
// Byte-wide circular store, one byte in, one 16-bit pair out. DEPTH must be a power of two.
module rx_byte_store #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned OCC_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [7:0]       push_byte_i,
  input  logic             pop_i,
  output logic [15:0]      head_o,
  output logic [OCC_W-1:0] occ_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q, rp_nx;
  logic [OCC_W-1:0] occ_q;

  assign rp_nx  = rp_q + PTR_W'(1);
  assign head_o = {mem_q[rp_nx], mem_q[rp_q]};
  assign occ_o  = occ_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wp_q] <= push_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + PTR_W'(1);
      if (pop_i)  rp_q <= rp_q + PTR_W'(2);
      occ_q <= occ_q + OCC_W'(push_i) - (pop_i ? OCC_W'(2) : OCC_W'(0));
    end
  end
endmodule

// File: rtl/rx_word_port.sv
module rx_word_port #(
  parameter int unsigned OCC_W = 7
) (
  input  logic [OCC_W-1:0] occ_i,
  input  logic [15:0]      head_i,
  input  logic             rd_i,
  output logic             word_req_o,
  output logic             pop_o,
  output logic [15:0]      data_o
);
  assign word_req_o = occ_i >= OCC_W'(2);
  assign pop_o      = rd_i && word_req_o;
  assign data_o     = word_req_o ? head_i : 16'h0000;
endmodule

// File: rtl/rx_pkt_ctrl.sv
module rx_pkt_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned OCC_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             rx_eop_i,
  input  logic             rx_err_i,
  input  logic             cnt_rd_i,
  input  logic [OCC_W-1:0] occ_i,
  output logic             push_o,
  output logic [7:0]       push_byte_o,
  output logic             nak_o,
  output logic             done_o,
  output logic [REG_W-1:0] cnt_o,
  output rx_state_e        state_o
);
  rx_state_e        state_q;
  logic [LEN_W-1:0] len_q, len_nx;
  logic             ovf_q, ovf_nx, err_q, done_q;
  logic             full, take, drop, is_open;

  assign is_open = state_q == ST_OPEN;
  assign full    = occ_i == OCC_W'(DEPTH);
  assign take    = is_open && rx_valid_i && !full;
  assign drop    = is_open && rx_valid_i && full;
  assign len_nx  = len_q + LEN_W'(take && !(&len_q));
  assign ovf_nx  = ovf_q || drop;

  // the pad byte keeps every packet word-aligned inside the store
  assign push_o      = take || (state_q == ST_PAD);
  assign push_byte_o = (state_q == ST_PAD) ? 8'h00 : rx_byte_i;
  assign nak_o       = !is_open;
  assign done_o      = done_q;
  assign cnt_o       = {is_open ? ovf_q : err_q, len_q};
  assign state_o     = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPEN;
      len_q   <= '0;
      ovf_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (flush_i) begin
      state_q <= ST_OPEN;
      len_q   <= '0;
      ovf_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= is_open && rx_eop_i;
      unique case (state_q)
        ST_OPEN: begin
          len_q <= len_nx;
          ovf_q <= ovf_nx;
          if (rx_eop_i) begin
            err_q   <= rx_err_i || ovf_nx;
            state_q <= len_nx[0] ? ST_PAD : ST_LOCKED;
          end
        end
        ST_PAD: state_q <= ST_LOCKED;
        ST_LOCKED: begin
          if (cnt_rd_i) begin
            state_q <= ST_OPEN;
            len_q   <= '0;
            ovf_q   <= 1'b0;
            err_q   <= 1'b0;
          end
        end
        default: state_q <= ST_OPEN;
      endcase
    end
  end
endmodule

// File: rtl/ep_rx_fifo.sv
module ep_rx_fifo
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_eop_i,
  input  logic        rx_err_i,
  output logic        rx_nak_o,
  input  logic        rd_word_i,
  output logic [15:0] rd_data_o,
  output logic        word_req_o,
  output logic        done_irq_o,
  input  logic        cnt_rd_i,
  output logic [15:0] cnt_o,
  input  logic        flush_i
);
  localparam int unsigned OCC_W = $clog2(DEPTH) + 1;

  logic             push, pop;
  logic [7:0]       push_byte;
  logic [15:0]      head;
  logic [OCC_W-1:0] occ;
  rx_state_e        state;

  rx_pkt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .flush_i, .rx_valid_i, .rx_byte_i, .rx_eop_i, .rx_err_i,
    .cnt_rd_i, .occ_i(occ), .push_o(push), .push_byte_o(push_byte),
    .nak_o(rx_nak_o), .done_o(done_irq_o), .cnt_o, .state_o(state)
  );

  rx_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .clr_i(flush_i), .push_i(push), .push_byte_i(push_byte),
    .pop_i(pop), .head_o(head), .occ_o(occ)
  );

  rx_word_port #(.OCC_W(OCC_W)) u_port (
    .occ_i(occ), .head_i(head), .rd_i(rd_word_i),
    .word_req_o, .pop_o(pop), .data_o(rd_data_o)
  );
endmodule

// File: rtl/ep_rx_fifo_sva.sv
module ep_rx_fifo_sva
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned OCC_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_eop_i,
  input logic             rx_nak_o,
  input logic             rd_word_i,
  input logic             word_req_o,
  input logic             done_irq_o,
  input logic             cnt_rd_i,
  input logic [15:0]      cnt_o,
  input logic             flush_i,
  input logic             push,
  input logic [OCC_W-1:0] occ,
  input rx_state_e        state
);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);

  assert_done_after_eop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_eop_i && !rx_nak_o && !flush_i) |=> done_irq_o);

  assert_locked_count_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_nak_o && !cnt_rd_i && !flush_i) |=> $stable(cnt_o));

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOCKED && cnt_rd_i) |=> (!rx_nak_o && cnt_o == 16'h0000));

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!word_req_o && !rx_nak_o && cnt_o == 16'h0000));

  assert_word_pop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_word_i && word_req_o && !push && !flush_i) |=> (occ == $past(occ) - OCC_W'(2)));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= OCC_W'(DEPTH));
endmodule

bind ep_rx_fifo ep_rx_fifo_sva #(.DEPTH(DEPTH)) i_sva (
  .clk_i, .rst_ni, .rx_eop_i, .rx_nak_o, .rd_word_i, .word_req_o, .done_irq_o,
  .cnt_rd_i, .cnt_o, .flush_i, .push, .occ, .state
);

// File: tb/test_ep_rx_fifo.sv
`timescale 1ns/1ps
module test_ep_rx_fifo;
  localparam int DEPTH = 64;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        rx_valid_i = 0, rx_eop_i = 0, rx_err_i = 0;
  logic [7:0]  rx_byte_i = '0;
  logic        rd_word_i = 0, cnt_rd_i = 0, flush_i = 0;
  logic        rx_nak_o, word_req_o, done_irq_o;
  logic [15:0] rd_data_o, cnt_o;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] q[$];
  int acc;
  bit ovf;

  always #4 clk = ~clk;

  ep_rx_fifo #(.DEPTH(DEPTH)) i_ep_rx_fifo (.clk_i(clk), .*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cnt_exp(input bit e, input int n);
    return {e, 15'(n)};
  endfunction

  task automatic push_bytes(input int n);
    acc = 0; ovf = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid_i = 1; rx_byte_i = 8'($urandom);
      if (q.size() < DEPTH) begin q.push_back(rx_byte_i); acc++; end
      else ovf = 1;
      @(negedge clk);
    end
    rx_valid_i = 0;
  endtask

  task automatic end_pkt(input bit e);
    rx_eop_i = 1; rx_err_i = e;
    @(negedge clk);
    rx_eop_i = 0; rx_err_i = 0;
    chk(done_irq_o === 1'b1, "R2 done pulse", done_irq_o, 1);
    chk(rx_nak_o === 1'b1, "R4 nak after eop", rx_nak_o, 1);
    chk(cnt_o === cnt_exp(e | ovf, acc), "R3 count", cnt_o, cnt_exp(e | ovf, acc));
    if (acc % 2 == 1) q.push_back(8'h00);
    @(negedge clk);
    chk(done_irq_o === 1'b0, "R2 done one cycle", done_irq_o, 0);
  endtask

  task automatic release_lock();
    cnt_rd_i = 1; @(negedge clk); cnt_rd_i = 0;
    chk(rx_nak_o === 1'b0 && cnt_o === 16'h0, "R5 release", {rx_nak_o, cnt_o}, 0);
  endtask

  task automatic read_all();
    while (q.size() >= 2) begin
      chk(word_req_o === 1'b1, "R1 word_req", word_req_o, 1);
      chk(rd_data_o === {q[1], q[0]}, "R1 word data", rd_data_o, {q[1], q[0]});
      rd_word_i = 1; @(negedge clk); rd_word_i = 0;
      void'(q.pop_front()); void'(q.pop_front());
    end
    chk(word_req_o === 1'b0, "R1 word_req drained", word_req_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b2;
    void'($urandom(32'd2024));
    #1;
    chk(rx_nak_o === 0 && word_req_o === 0 && done_irq_o === 0 && cnt_o === 0,
        "R11 reset", {rx_nak_o, word_req_o, done_irq_o, cnt_o}, 0);
    @(negedge clk); rst_ni = 1; @(negedge clk);

    // R6: three bytes, last word padded
    push_bytes(3); b0 = q[0]; b2 = q[2];
    end_pkt(0);
    release_lock();
    chk(rd_data_o[7:0] === b0, "R1 first byte low", rd_data_o[7:0], b0);
    rd_word_i = 1; @(negedge clk); rd_word_i = 0;
    chk(rd_data_o === {8'h00, b2}, "R6 odd pad", rd_data_o, {8'h00, b2});
    void'(q.pop_front()); void'(q.pop_front());
    read_all();

    // R7: zero length
    push_bytes(0); end_pkt(1);
    chk(word_req_o === 0 && rx_nak_o === 1, "R7 zero length locked", {word_req_o, rx_nak_o}, 1);
    repeat (3) @(negedge clk);
    chk(rx_nak_o === 1, "R7 lock held", rx_nak_o, 1);
    release_lock();
    chk(word_req_o === 0, "R7 no word", word_req_o, 0);

    // R4: traffic while locked is refused
    push_bytes(2); end_pkt(0);
    for (int i = 0; i < 3; i++) begin rx_valid_i = 1; rx_byte_i = 8'hA5; @(negedge clk); end
    rx_valid_i = 0; rx_eop_i = 1; @(negedge clk); rx_eop_i = 0;
    chk(done_irq_o === 0 && cnt_o === cnt_exp(0, 2), "R4 ignored while locked", cnt_o, cnt_exp(0, 2));
    release_lock();
    read_all();

    // R10: read strobes with nothing available, count read while open
    rd_word_i = 1; @(negedge clk); rd_word_i = 0;
    chk(word_req_o === 0, "R10 empty read", word_req_o, 0);
    push_bytes(2);
    cnt_rd_i = 1; @(negedge clk); cnt_rd_i = 0;
    chk(cnt_o === cnt_exp(0, 2) && rx_nak_o === 0, "R10 count read open", cnt_o, cnt_exp(0, 2));
    push_bytes(1); acc = 3; end_pkt(0);
    release_lock();
    push_bytes(4); end_pkt(0); release_lock();  // backlog of two packets
    read_all();

    // R8: overflow
    push_bytes(DEPTH + 3);
    chk(acc == DEPTH, "R8 model", acc, DEPTH);
    end_pkt(0);
    chk(cnt_o === cnt_exp(1, DEPTH), "R8 overflow flag", cnt_o, cnt_exp(1, DEPTH));
    release_lock(); read_all();

    // R9: flush while locked and mid-packet
    push_bytes(5); end_pkt(0);
    flush_i = 1; @(negedge clk); flush_i = 0; q.delete();
    chk(word_req_o === 0 && rx_nak_o === 0 && cnt_o === 0, "R9 flush locked", {word_req_o, rx_nak_o, cnt_o}, 0);
    push_bytes(7);
    flush_i = 1; @(negedge clk); flush_i = 0; q.delete();
    chk(word_req_o === 0 && cnt_o === 0, "R9 flush open", {word_req_o, cnt_o}, 0);
    push_bytes(2); end_pkt(0); release_lock(); read_all();

    // random packets, random order of release and drain
    for (int k = 0; k < 60; k++) begin
      int n;
      bit e, first_release;
      n = int'($urandom % (DEPTH + 1));
      e = 1'($urandom);
      first_release = 1'($urandom);
      push_bytes(n); end_pkt(e);
      if (first_release) begin release_lock(); read_all(); end
      else begin read_all(); release_lock(); end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule